// File: doc/BRIEF.md
# Handshake FIFO Channel

This block links one producer and one consumer through a valid/ready handshake with a small queue in between. The producer raises a put strobe with its data and the item is taken on any clock edge where the channel signals ready. The consumer sees a request flag with the item at the head of the queue and removes it by raising a get strobe. Either side may withdraw its strobe late in the cycle through a cancel input, so the put or get of that cycle has no effect.

Elaboration parameters choose the queue depth and the timing of each handshake path. The depth may be zero, which gives a pass-through for a consumer that always takes what is offered. The request path and the ready path can each be either combinational or registered, independently of each other. An element count and an almost-full flag against a runtime threshold come out alongside. The data output never shows an undefined value: when nothing is pending it repeats the last item it presented, and it reads as zero until the first item arrives. Storage can be cleared on reset by parameter. The reset input asserts asynchronously and is released inside the block on the rising clock edge.

Top module: `hsfc_chan`

## Requirements
- R1: While reset is held and for two clock edges after it is released, ready_o and req_o are 0. After that, with no activity, req_o is 0, count_o is 0 and data_o is 0, and ready_o is 1 for a depth of one or more.
- R2: Every accepted item reaches the consumer exactly once, in the order it was accepted. An item is accepted on a rising edge where put_i=1, put_cancel_i=0 and ready_o=1. It is removed on an edge where req_o=1, get_i=1 and get_cancel_i=0.
- R3: With the queue full and no removal in that cycle, ready_o is 0, no put is taken, and count_o stays at DEPTH.
- R4: With combinational ready, a full queue raises ready_o in any cycle that removes an item. The put of that cycle is then taken without losing data, and count_o stays at DEPTH.
- R5: With a combinational request path and an empty queue, a put raises req_o in the same cycle, with data_o equal to put_data_i.
- R6: With a registered request path, req_o rises on the clock edge after the first put into an empty queue, never in the cycle of the put.
- R7: With registered ready, ready_o is a register loaded with (next count < DEPTH). At DEPTH=2 with both paths registered, a producer and consumer that strobe every cycle move one item per cycle. Once the count reaches DEPTH, ready_o reads 0.
- R8: A put with put_cancel_i=1 writes nothing: count_o and the queue contents are unchanged.
- R9: A get with get_cancel_i=1 removes nothing: the head item stays on data_o and count_o is unchanged.
- R10: When req_o is 0, data_o holds the value it presented last, which is 0 if nothing has been presented since reset.
- R11: count_o gives the number of stored items as of the last clock edge. almost_full_o is 1 when count_o >= DEPTH - thresh_i, and it is 1 whenever thresh_i >= DEPTH.
- R12: At DEPTH=0 nothing is stored. ready_o is 1 out of reset, req_o equals put_i and not put_cancel_i in the same cycle, data_o equals put_data_i while req_o is 1, and count_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_n_i | input | 1 | Asynchronous active-low reset |
| put_i | input | 1 | Producer put strobe |
| put_data_i | input | W | Producer data |
| put_cancel_i | input | 1 | Withdraws this cycle's put |
| ready_o | output | 1 | Channel can take a put this cycle |
| req_o | output | 1 | An item is pending for the consumer |
| data_o | output | W | Head item, or last presented item when idle |
| get_i | input | 1 | Consumer get strobe |
| get_cancel_i | input | 1 | Withdraws this cycle's get |
| thresh_i | input | CW | Almost-full margin below DEPTH |
| count_o | output | CW | Stored item count |
| almost_full_o | output | 1 | count_o >= DEPTH - thresh_i |

## Verification
The bench targets the full queue that is read and written in the same cycle. A ready path that ignores the removal would stall the producer there, and one that forgets the full state would overwrite the head. It fires cancels on both sides and tracks the head item. A design that dropped either cancel would then show a changed count or a skipped item in the scoreboard. It checks data_o after the queue drains and straight after reset, where a missing hold register would show stale storage or undefined bits. It checks that an empty combinational queue hands a put through in the same cycle, that a registered request path delays it by exactly one edge, and that a depth-two queue with both paths registered keeps one transfer per cycle. A design that lost the bypass or mis-sized the registered ready would fail these on timing.

// File: rtl/hsfc_pkg.sv
package hsfc_pkg;

  // Index width for a buffer of d entries (at least one bit).
  function automatic int ptr_w(input int d);
    return (d > 1) ? $clog2(d) : 1;
  endfunction

  // Width able to hold the values 0..d (at least one bit).
  function automatic int cnt_w(input int d);
    return (d > 0) ? $clog2(d + 1) : 1;
  endfunction

endpackage

// File: rtl/hsfc_rst_sync.sv
module hsfc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_n_i,
  output logic rst_n_o
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_n_o = sync_q[STAGES-1];

endmodule

// File: rtl/hsfc_store.sv
module hsfc_store #(
  parameter int W        = 8,
  parameter int DEPTH    = 4,
  parameter bit INIT_BUF = 1'b0,
  localparam int PW      = hsfc_pkg::ptr_w(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_n_i,
  input  logic          wr_en_i,
  input  logic [PW-1:0] wr_ptr_i,
  input  logic [W-1:0]  wr_data_i,
  input  logic [PW-1:0] rd_ptr_i,
  output logic [W-1:0]  rd_data_o
);

  logic [W-1:0] mem_q [DEPTH];

  generate
    for (genvar e = 0; e < DEPTH; e++) begin : g_entry
      logic hit;
      assign hit = wr_en_i && (wr_ptr_i == PW'(e));
      if (INIT_BUF) begin : g_clr
        always_ff @(posedge clk_i or negedge rst_n_i) begin
          if (!rst_n_i) begin
            mem_q[e] <= '0;
          end else if (hit) begin
            mem_q[e] <= wr_data_i;
          end
        end
      end else begin : g_raw
        always_ff @(posedge clk_i) begin
          if (hit) begin
            mem_q[e] <= wr_data_i;
          end
        end
      end
    end
  endgenerate

  assign rd_data_o = mem_q[rd_ptr_i];

endmodule

// File: rtl/hsfc_ctrl.sv
module hsfc_ctrl #(
  parameter int DEPTH      = 4,
  parameter bit SYNC_VALID = 1'b0,
  parameter bit SYNC_READY = 1'b0,
  localparam int PW        = hsfc_pkg::ptr_w(DEPTH),
  localparam int CW        = hsfc_pkg::cnt_w(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_n_i,
  input  logic          put_i,
  input  logic          put_cancel_i,
  input  logic          get_i,
  input  logic          get_cancel_i,
  output logic          ready_o,
  output logic          req_o,
  output logic          empty_o,
  output logic          wr_en_o,
  output logic [PW-1:0] wr_ptr_o,
  output logic [PW-1:0] rd_ptr_o,
  output logic [CW-1:0] count_o
);

  localparam logic [PW-1:0] LAST_IDX = PW'(DEPTH - 1);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

  logic [CW-1:0] count_q, count_d;
  logic [PW-1:0] wp_q, wp_d, rp_q, rp_d;
  logic          rdy_q, rdy_d;
  logic          empty, full, put_ok, pop, enq, bypass, wr_en, rd_en;

  // Handshake decode
  always_comb begin
    empty   = (count_q == '0);
    full    = (count_q == FULL_CNT);
    put_ok  = put_i && !put_cancel_i;
    req_o   = rst_n_i && (!empty || (!SYNC_VALID && put_ok));
    pop     = req_o && get_i && !get_cancel_i;
    ready_o = rst_n_i && (SYNC_READY ? rdy_q : (!full || pop));
    enq     = put_ok && ready_o;
    bypass  = empty && enq && pop;
    wr_en   = enq && !bypass;
    rd_en   = pop && !bypass;
  end

  // Next state
  always_comb begin
    count_d = count_q;
    unique case ({wr_en, rd_en})
      2'b10:   count_d = count_q + 1'b1;
      2'b01:   count_d = count_q - 1'b1;
      default: count_d = count_q;
    endcase
    wp_d  = wr_en ? ((wp_q == LAST_IDX) ? '0 : wp_q + 1'b1) : wp_q;
    rp_d  = rd_en ? ((rp_q == LAST_IDX) ? '0 : rp_q + 1'b1) : rp_q;
    rdy_d = (count_d < FULL_CNT);
  end

  // State registers
  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      count_q <= '0;
      wp_q    <= '0;
      rp_q    <= '0;
      rdy_q   <= 1'b1;
    end else begin
      count_q <= count_d;
      wp_q    <= wp_d;
      rp_q    <= rp_d;
      rdy_q   <= rdy_d;
    end
  end

  assign empty_o  = empty;
  assign wr_en_o  = wr_en;
  assign wr_ptr_o = wp_q;
  assign rd_ptr_o = rp_q;
  assign count_o  = count_q;

  // R3: the count never passes the depth
  assert_no_overflow_R3: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    count_q <= FULL_CNT);

  // R3: a full queue with no get offers no ready
  assert_full_no_ready_R3: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (full && !get_i) |-> !ready_o);

  // R8: a withdrawn put with no removal leaves the count alone
  assert_cancel_put_R8: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (put_i && put_cancel_i && !pop) |=> (count_q == $past(count_q)));

  // R9: a withdrawn get with no write leaves the count alone
  assert_cancel_get_R9: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (get_i && get_cancel_i && !enq) |=> (count_q == $past(count_q)));

  generate
    if (SYNC_VALID) begin : g_sv_chk
      // R6: a registered request only rises after a stored write
      assert_req_after_write_R6: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        $rose(req_o) |-> $past(wr_en));
    end
  endgenerate

endmodule

// File: rtl/hsfc_chan.sv
module hsfc_chan #(
  parameter int W          = 8,
  parameter int DEPTH      = 4,
  parameter bit SYNC_VALID = 1'b0,
  parameter bit SYNC_READY = 1'b0,
  parameter bit INIT_BUF   = 1'b0,
  parameter int RST_STAGES = 2,
  localparam int CW        = hsfc_pkg::cnt_w(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_n_i,
  input  logic          put_i,
  input  logic [W-1:0]  put_data_i,
  input  logic          put_cancel_i,
  output logic          ready_o,
  output logic          req_o,
  output logic [W-1:0]  data_o,
  input  logic          get_i,
  input  logic          get_cancel_i,
  input  logic [CW-1:0] thresh_i,
  output logic [CW-1:0] count_o,
  output logic          almost_full_o
);

  localparam logic [CW:0] DEPTH_X = (CW+1)'(DEPTH);

  logic         rst_n_s;
  logic [W-1:0] cur_data;
  logic [W-1:0] last_q, last_d;
  logic         last_en;

  hsfc_rst_sync #(.STAGES(RST_STAGES)) u_rst_sync (
    .clk_i   (clk_i),
    .rst_n_i (rst_n_i),
    .rst_n_o (rst_n_s)
  );

  generate
    if (DEPTH == 0) begin : g_pass
      assign ready_o  = rst_n_s;
      assign req_o    = rst_n_s && put_i && !put_cancel_i;
      assign cur_data = put_data_i;
      assign count_o  = '0;
    end else begin : g_queue
      localparam int PW = hsfc_pkg::ptr_w(DEPTH);
      logic          empty, wr_en;
      logic [PW-1:0] wr_ptr, rd_ptr;
      logic [W-1:0]  rd_data;

      hsfc_ctrl #(
        .DEPTH      (DEPTH),
        .SYNC_VALID (SYNC_VALID),
        .SYNC_READY (SYNC_READY)
      ) u_ctrl (
        .clk_i        (clk_i),
        .rst_n_i      (rst_n_s),
        .put_i        (put_i),
        .put_cancel_i (put_cancel_i),
        .get_i        (get_i),
        .get_cancel_i (get_cancel_i),
        .ready_o      (ready_o),
        .req_o        (req_o),
        .empty_o      (empty),
        .wr_en_o      (wr_en),
        .wr_ptr_o     (wr_ptr),
        .rd_ptr_o     (rd_ptr),
        .count_o      (count_o)
      );

      hsfc_store #(
        .W        (W),
        .DEPTH    (DEPTH),
        .INIT_BUF (INIT_BUF)
      ) u_store (
        .clk_i     (clk_i),
        .rst_n_i   (rst_n_s),
        .wr_en_i   (wr_en),
        .wr_ptr_i  (wr_ptr),
        .wr_data_i (put_data_i),
        .rd_ptr_i  (rd_ptr),
        .rd_data_o (rd_data)
      );

      // An empty combinational queue shows the incoming put directly
      assign cur_data = (!SYNC_VALID && empty) ? put_data_i : rd_data;
    end
  endgenerate

  // Held output: repeat the last presented item while idle
  always_comb begin
    last_en = req_o;
    last_d  = cur_data;
    data_o  = req_o ? cur_data : last_q;
  end

  always_ff @(posedge clk_i or negedge rst_n_s) begin
    if (!rst_n_s) begin
      last_q <= '0;
    end else if (last_en) begin
      last_q <= last_d;
    end
  end

  // Almost-full against the runtime margin
  always_comb begin
    almost_full_o = ({1'b0, thresh_i} >= DEPTH_X) ||
                    ({1'b0, count_o} >= (DEPTH_X - {1'b0, thresh_i}));
  end

  // R10: an idle output repeats what it showed on the previous edge
  assert_hold_data_R10: assert property (@(posedge clk_i) disable iff (!rst_n_s)
    !req_o |-> (data_o == $past(data_o)));

  // R1: nothing is offered while the synchronized reset is active
  assert_quiet_reset_R1: assert property (@(posedge clk_i)
    !rst_n_s |-> (!req_o && !ready_o));

endmodule

// File: tb/hsfc_chan_tb.sv
module hsfc_chan_tb;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // Main unit: depth 4, combinational paths
  logic       put = 0, pcan = 0, get = 0, gcan = 0;
  logic [7:0] pdat = '0;
  logic [2:0] thr = '0;
  logic       rdy, req, af;
  logic [7:0] dat;
  logic [2:0] cnt;

  hsfc_chan #(.W(8), .DEPTH(4)) u_dut (
    .clk_i(clk), .rst_n_i(rst_n), .put_i(put), .put_data_i(pdat),
    .put_cancel_i(pcan), .ready_o(rdy), .req_o(req), .data_o(dat),
    .get_i(get), .get_cancel_i(gcan), .thresh_i(thr), .count_o(cnt),
    .almost_full_o(af));

  // Registered paths, depth 2
  logic       s_put = 0, s_get = 0;
  logic [7:0] s_pdat = '0;
  logic       s_rdy, s_req, s_af;
  logic [7:0] s_dat;
  logic [1:0] s_cnt;

  hsfc_chan #(.W(8), .DEPTH(2), .SYNC_VALID(1'b1), .SYNC_READY(1'b1), .INIT_BUF(1'b1)) u_sync (
    .clk_i(clk), .rst_n_i(rst_n), .put_i(s_put), .put_data_i(s_pdat),
    .put_cancel_i(1'b0), .ready_o(s_rdy), .req_o(s_req), .data_o(s_dat),
    .get_i(s_get), .get_cancel_i(1'b0), .thresh_i(2'd0), .count_o(s_cnt),
    .almost_full_o(s_af));

  // Zero depth pass-through
  logic       z_put = 0, z_pcan = 0;
  logic [7:0] z_pdat = '0;
  logic       z_rdy, z_req, z_af;
  logic [7:0] z_dat;
  logic [0:0] z_cnt;

  hsfc_chan #(.W(8), .DEPTH(0)) u_pass (
    .clk_i(clk), .rst_n_i(rst_n), .put_i(z_put), .put_data_i(z_pdat),
    .put_cancel_i(z_pcan), .ready_o(z_rdy), .req_o(z_req), .data_o(z_dat),
    .get_i(1'b1), .get_cancel_i(1'b0), .thresh_i(1'b0), .count_o(z_cnt),
    .almost_full_o(z_af));

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic report();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  // Drive the main unit at the falling edge, settle comb outputs
  task automatic drv(input logic p, input logic [7:0] d, input logic pc,
                     input logic g, input logic gc);
    @(negedge clk);
    put = p; pdat = d; pcan = pc; get = g; gcan = gc;
    #1;
  endtask

  // Scoreboard for the main unit (R2)
  logic [7:0] exp_q[$];
  always @(negedge clk) begin
    #2;
    if (put && !pcan && rdy) exp_q.push_back(pdat);
    if (req && get && !gcan) begin
      if (exp_q.size() == 0) begin
        checks++; fails++;
        $display("FAIL R2 unexpected pop actual=%0h expected=none", dat);
      end else begin
        chk("R2 order", dat, exp_q.pop_front());
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL R2 watchdog expired actual=0 expected=1");
    report();
  end

  initial begin
    int acc, popn;
    repeat (3) @(negedge clk);
    chk("R1 ready held in reset", rdy, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // Reset state
    drv(0, 0, 0, 0, 0);
    chk("R1 ready", rdy, 1);
    chk("R1 req", req, 0);
    chk("R1 count", cnt, 0);
    chk("R10 data zero after reset", dat, 0);
    chk("R1 sync req", s_req, 0);
    chk("R10 sync data zero", s_dat, 0);
    chk("R12 pass ready", z_rdy, 1);

    // R5 bypass into empty queue
    drv(1, 8'h11, 0, 0, 0);
    chk("R5 req same cycle", req, 1);
    chk("R5 data same cycle", dat, 8'h11);
    drv(1, 8'h22, 0, 0, 0);
    chk("R11 count one", cnt, 1);
    drv(1, 8'h33, 0, 0, 0);
    drv(1, 8'h44, 0, 0, 0);

    // R3 full blocks put
    thr = 3'd0;
    drv(1, 8'h55, 0, 0, 0);
    chk("R3 ready low when full", rdy, 0);
    chk("R3 count at depth", cnt, 4);
    chk("R11 almost full at depth", af, 1);

    // R4 full with get
    drv(1, 8'h55, 0, 1, 0);
    chk("R4 ready with get", rdy, 1);
    chk("R4 head shown", dat, 8'h11);

    // R9 cancelled get
    drv(0, 0, 0, 1, 1);
    chk("R4 count stays full", cnt, 4);
    chk("R9 head shown", dat, 8'h22);
    drv(0, 0, 0, 1, 0);
    chk("R9 count kept", cnt, 4);
    chk("R9 head kept", dat, 8'h22);

    // R8 cancelled put
    drv(1, 8'h66, 1, 0, 0);
    chk("R8 count before", cnt, 3);
    drv(0, 0, 0, 0, 0);
    chk("R8 count unchanged", cnt, 3);
    thr = 3'd1; #1;
    chk("R11 almost full margin one", af, 1);
    thr = 3'd0; #1;
    chk("R11 not almost full", af, 0);
    thr = 3'd5; #1;
    chk("R11 margin above depth", af, 1);
    thr = 3'd0;

    // Drain, then R10 hold
    do drv(0, 0, 0, 1, 0); while (req);
    chk("R10 data held after drain", dat, 8'h55);
    chk("R11 count empty", cnt, 0);
    drv(0, 0, 0, 0, 0);
    chk("R10 data still held", dat, 8'h55);

    // Random traffic through the scoreboard
    for (int i = 0; i < 600; i++) begin
      drv(($urandom % 3) != 0, 8'($urandom), ($urandom % 8) == 0,
          ($urandom % 3) != 0, ($urandom % 8) == 0);
    end
    repeat (8) drv(0, 0, 0, 1, 0);
    drv(0, 0, 0, 0, 0);
    chk("R2 all items delivered", exp_q.size(), 0);
    chk("R2 req low after drain", req, 0);

    // R6 registered request path
    @(negedge clk); s_put = 1; s_pdat = 8'h10; s_get = 0; #1;
    chk("R6 no req in put cycle", s_req, 0);
    @(negedge clk); s_put = 0; #1;
    chk("R6 req one edge later", s_req, 1);
    chk("R6 data", s_dat, 8'h10);
    @(negedge clk); s_get = 1; #1;
    @(negedge clk); s_get = 0; #1;
    chk("R6 empty again", s_req, 0);

    // R7 full rate at depth 2, registered paths
    acc = 0; popn = 0;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk); s_put = 1; s_pdat = 8'(i); s_get = 1; #1;
      if (s_rdy) acc++;
      if (s_req) begin
        chk("R7 stream order", s_dat, popn);
        popn++;
      end
    end
    chk("R7 puts taken every cycle", acc, 12);
    chk("R7 gets every cycle", popn, 11);
    @(negedge clk); s_pdat = 8'd12; s_get = 0; #1;
    chk("R7 ready below depth", s_rdy, 1);
    @(negedge clk); s_put = 0; #1;
    chk("R7 count at depth", s_cnt, 2);
    chk("R7 ready low at depth", s_rdy, 0);

    // R12 zero depth pass-through
    @(negedge clk); z_put = 1; z_pdat = 8'hA5; #1;
    chk("R12 req follows put", z_req, 1);
    chk("R12 data follows put", z_dat, 8'hA5);
    chk("R12 count zero", z_cnt, 0);
    @(negedge clk); z_pcan = 1; z_pdat = 8'h3C; #1;
    chk("R12 cancel drops req", z_req, 0);
    chk("R10 pass data held", z_dat, 8'hA5);

    @(negedge clk);
    report();
  end

endmodule